// File: doc/BRIEF.md
# Indirect 16-bit RAM access sequencer

This block lets a client read or write one 16-bit word of an external RAM that can only be reached through byte-wide indirect registers behind a register-access port. The client hands over a single request with a direction flag, a 16-bit word address and a 16-bit write word. The sequencer turns it into four separate single-register transactions. Each transaction is started with a one-cycle start pulse and completed by a done pulse from the port, which frames it as its own chip-select cycle.

Every access first loads the address pointer. The high address byte goes to register 0x1A and the low byte to 0x1B. A write then stores the data high byte and after it the data low byte, both into data register 0x1C. A read instead performs two reads of register 0x1D. The first returns the low byte and the second the high byte. The result is (second << 8) + first. It is registered and flagged with a one-cycle valid pulse, and a write ends with a one-cycle done pulse.

Top module: `ram_indirect_seq`

## Requirements
- R1: After reset, busy, txn_start, rd_valid and wr_done are all 0.
- R2: Every access begins with a register write of the address high byte to register 0x1A, followed by a register write of the address low byte to register 0x1B.
- R3: After the address, a write access issues a register write of data bits 15:8 to register 0x1C, then a register write of data bits 7:0 to register 0x1C.
- R4: After the address, a read access issues two register reads (txn_write = 0) of register 0x1D. rd_data equals {second returned byte, first returned byte}.
- R5: Each access issues exactly four transactions. Each txn_start is a single-cycle pulse. The next transaction starts only after txn_done has been seen for the current one, for any response latency.
- R6: busy rises in the cycle after a request is accepted and stays high until the fourth transaction completes. A req_valid seen while busy is ignored: it neither changes the transaction series nor starts a new access.
- R7: A read ends with rd_valid high for exactly one cycle, in the cycle busy falls. rd_data changes only together with rd_valid and holds its value otherwise.
- R8: A write ends with wr_done high for exactly one cycle, in the cycle busy falls, and rd_valid stays low.
- R9: A txn_done pulse arriving while the sequencer is idle is ignored: no transaction starts and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken when not busy |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | RAM word address |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Access in progress |
| rd_data | output | 16 | Last word read |
| rd_valid | output | 1 | One-cycle pulse: rd_data updated |
| wr_done | output | 1 | One-cycle pulse: write finished |
| txn_start | output | 1 | One-cycle pulse starting a register transaction |
| txn_write | output | 1 | 1 = register write, 0 = register read |
| txn_reg | output | 8 | Register number of the transaction |
| txn_wbyte | output | 8 | Byte to write to the register |
| txn_done | input | 1 | Transaction finished (one cycle) |
| txn_rbyte | input | 8 | Byte returned by a register read, valid with txn_done |

## Verification
The assertions assume that the register port answers each txn_start with exactly one txn_done pulse. They also assume that this pulse comes at least one cycle after the start, never in the same cycle as txn_start, and that txn_rbyte is valid with it. The bench's port model keeps to this by sampling txn_start on the falling edge and raising txn_done one to four cycles later. It holds txn_done for a single cycle and returns the byte that a small modelled RAM would give. The only txn_done the bench drives outside that model is one deliberate stray pulse while the block is idle, which is the case the block must ignore.

// File: rtl/ram_indirect_seq.sv
module ram_indirect_seq #(
  parameter int BW = 8,
  parameter int RW = 8,
  parameter logic [RW-1:0] REG_PTR_HI = 8'h1A,
  parameter logic [RW-1:0] REG_PTR_LO = 8'h1B,
  parameter logic [RW-1:0] REG_WPORT  = 8'h1C,
  parameter logic [RW-1:0] REG_RPORT  = 8'h1D,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [WW-1:0] req_addr,
  input  logic [WW-1:0] req_wdata,
  output logic          busy,
  output logic [WW-1:0] rd_data,
  output logic          rd_valid,
  output logic          wr_done,
  output logic          txn_start,
  output logic          txn_write,
  output logic [RW-1:0] txn_reg,
  output logic [BW-1:0] txn_wbyte,
  input  logic          txn_done,
  input  logic [BW-1:0] txn_rbyte
);

  logic [1:0]    step;
  logic          is_wr;
  logic [WW-1:0] addr_q, wdata_q;
  logic [BW-1:0] lo_q;
  logic          waiting;

  assign waiting   = busy && !txn_start;
  assign txn_write = !step[1] || is_wr;

  always_comb begin
    txn_reg   = REG_RPORT;
    txn_wbyte = '0;
    case (step)
      2'd0: begin txn_reg = REG_PTR_HI; txn_wbyte = addr_q[WW-1:BW]; end
      2'd1: begin txn_reg = REG_PTR_LO; txn_wbyte = addr_q[BW-1:0]; end
      2'd2: if (is_wr) begin txn_reg = REG_WPORT; txn_wbyte = wdata_q[WW-1:BW]; end
      default: if (is_wr) begin txn_reg = REG_WPORT; txn_wbyte = wdata_q[BW-1:0]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= 2'd0;
      is_wr     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      lo_q      <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      wr_done   <= 1'b0;
      txn_start <= 1'b0;
    end else begin
      txn_start <= 1'b0;
      rd_valid  <= 1'b0;
      wr_done   <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy      <= 1'b1;
          step      <= 2'd0;
          is_wr     <= req_write;
          addr_q    <= req_addr;
          wdata_q   <= req_wdata;
          txn_start <= 1'b1;
        end
      end else if (waiting && txn_done) begin
        if (step == 2'd2 && !is_wr) lo_q <= txn_rbyte;
        if (step == 2'd3) begin
          busy <= 1'b0;
          if (is_wr) wr_done <= 1'b1;
          else begin
            rd_valid <= 1'b1;
            rd_data  <= {txn_rbyte, lo_q};
          end
        end else begin
          step      <= step + 2'd1;
          txn_start <= 1'b1;
        end
      end
    end
  end

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> !txn_start) else $error("txn_start longer than one cycle");

  p_wait_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !txn_start && !txn_done) |=> (!txn_start && $stable(step)))
    else $error("transaction advanced without done");

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> busy) else $error("transaction started while idle");

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(waiting && txn_done && step == 2'd3)) |=> busy)
    else $error("busy dropped early");

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> (!busy && !txn_start))
    else $error("idle sequencer woke without request");

  p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_done) |-> (!busy && $past(busy)))
    else $error("completion pulse outside busy fall");

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_done)) else $error("rd_valid with wr_done");

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> rd_valid) else $error("rd_data changed without rd_valid");

endmodule

// File: tb/tb_ram_indirect_seq.sv
`timescale 1ns/1ps
module tb_ram_indirect_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, rd_valid, wr_done, txn_start, txn_write;
  logic [15:0] rd_data;
  logic [7:0]  txn_reg, txn_wbyte;
  logic        txn_done = 1'b0;
  logic [7:0]  txn_rbyte = '0;

  ram_indirect_seq dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int lat_cfg = 0;
  int trc_n = 0;
  logic [7:0] trc_reg [8];
  logic [7:0] trc_wb [8];
  logic       trc_wr [8];
  logic [15:0] dev_addr = '0;
  int rd_idx = 0;
  bit finished = 0;

  function automatic logic [15:0] mem_val(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register-port model: done 1..4 cycles after start
  initial begin
    forever begin
      @(negedge clk);
      if (txn_done) txn_done = 1'b0;
      if (txn_start) begin
        if (trc_n < 8) begin
          trc_reg[trc_n] = txn_reg; trc_wb[trc_n] = txn_wbyte; trc_wr[trc_n] = txn_write;
        end
        trc_n++;
        if (txn_write && txn_reg == 8'h1A) begin dev_addr[15:8] = txn_wbyte; rd_idx = 0; end
        if (txn_write && txn_reg == 8'h1B) dev_addr[7:0] = txn_wbyte;
        repeat (lat_cfg + 1) @(negedge clk);
        if (!txn_write && txn_reg == 8'h1D) begin
          txn_rbyte = (rd_idx == 0) ? mem_val(dev_addr)[7:0] : mem_val(dev_addr)[15:8];
          rd_idx++;
        end else txn_rbyte = 8'hEE;
        txn_done = 1'b1;
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d, input bit poke);
    logic [15:0] prev = rd_data;
    trc_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R6 busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R6 busy held during ignored request", busy, 1);
    end
    wait_idle();
    chk(busy == 1'b0, "R6 busy falls", busy, 0);
    chk(trc_n == 4, "R5 four transactions", trc_n, 4);
    chk(trc_reg[0] == 8'h1A && trc_wr[0] && trc_wb[0] == a[15:8], "R2 addr hi to 0x1A",
        {trc_wr[0], trc_reg[0], trc_wb[0]}, {1'b1, 8'h1A, a[15:8]});
    chk(trc_reg[1] == 8'h1B && trc_wr[1] && trc_wb[1] == a[7:0], "R2 addr lo to 0x1B",
        {trc_wr[1], trc_reg[1], trc_wb[1]}, {1'b1, 8'h1B, a[7:0]});
    if (wr) begin
      chk(trc_reg[2] == 8'h1C && trc_wr[2] && trc_wb[2] == d[15:8], "R3 data hi to 0x1C",
          {trc_wr[2], trc_reg[2], trc_wb[2]}, {1'b1, 8'h1C, d[15:8]});
      chk(trc_reg[3] == 8'h1C && trc_wr[3] && trc_wb[3] == d[7:0], "R3 data lo to 0x1C",
          {trc_wr[3], trc_reg[3], trc_wb[3]}, {1'b1, 8'h1C, d[7:0]});
      chk(wr_done && !rd_valid, "R8 wr_done pulse, no rd_valid", {wr_done, rd_valid}, 2'b10);
      chk(rd_data == prev, "R7 rd_data held on write", rd_data, prev);
    end else begin
      chk(trc_reg[2] == 8'h1D && !trc_wr[2], "R4 first read of 0x1D", {trc_wr[2], trc_reg[2]}, 9'h01D);
      chk(trc_reg[3] == 8'h1D && !trc_wr[3], "R4 second read of 0x1D", {trc_wr[3], trc_reg[3]}, 9'h01D);
      chk(rd_valid && !wr_done, "R7 rd_valid pulse", {rd_valid, wr_done}, 2'b10);
      chk(rd_data == mem_val(a), "R4 read word", rd_data, mem_val(a));
    end
    @(negedge clk);
    chk(!rd_valid && !wr_done, "R7 R8 single-cycle completion", {rd_valid, wr_done}, 0);
    chk(!busy && trc_n == 4, "R6 ignored request started nothing", {busy, 8'(trc_n)}, 4);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !txn_start && !rd_valid && !wr_done, "R1 outputs under reset",
        {busy, txn_start, rd_valid, wr_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !txn_start && !rd_valid && !wr_done, "R1 reset state",
        {busy, txn_start, rd_valid, wr_done}, 0);

    txn_done = 1'b1;
    @(negedge clk);
    txn_done = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !txn_start, "R9 stray done ignored", {busy, txn_start}, 0);

    for (int i = 0; i < 24; i++) begin
      logic [15:0] a = 16'(i * 16'h2B47 + 16'h0101);
      logic [15:0] d = 16'(i * 16'h6D1B ^ 16'hC3A5);
      if (i == 0) a = 16'h0000;
      if (i == 1) a = 16'hFFFF;
      lat_cfg = i % 4;
      access(1'b1, a, d, 1'b0);
      access(1'b0, a, 16'h0, 1'b0);
    end
    lat_cfg = 2;
    access(1'b1, 16'h1234, 16'hBEEF, 1'b1);
    access(1'b0, 16'h4321, 16'h0, 1'b1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule